// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs single read or write transfers on an external memory bus in which the low address byte and the data byte share one 8-bit port. A second port carries the high part of the address. Every transfer is built from two clock phases. In the first phase the address is put on both ports and an address latch strobe is raised. In the second phase a data strobe is raised, and the shared port either carries write data or is released so that read data can be captured. An active-low wait input repeats the second phase for as long as it is held low. Each phase lasts one clock of the block.

A core issues one transfer at a time with a request/ready handshake. A mode input picks one of two strobe styles. In the first style there is an active-low address strobe, an active-low data strobe and a read/write level. In the second style there is an active-high address latch enable, and the data-strobe and read/write pins act as separate active-low read and write strobes. Pad tristate buffers are modelled as output enables. Software can float every bus output, and an external master can take the bus with an active-low request, which the block answers with an active-low acknowledge.

Bus requests are looked at only in second-type phases. The idle bus alternates between a first-type and a second-type phase, so an idle bus is granted within two clocks. A busy bus is granted only after the current transfer ends.

Top module: `mux_bus_ctrl`

## Requirements
- R1: During and right after a synchronous reset the block is idle: `core_ready`=1, `bus_ack_n`=1, `core_rvalid`=0, `mux_oe`=0, `rw_pin`=1 (read level), and in strobe mode 0 `addr_strobe`=1 and `data_strobe`=1.
- R2: A request accepted at a clock edge (`core_req` and `core_ready` both high) starts the address phase on the next clock. In that phase the address strobe is active, `mux_out`=address[7:0] and `hi_addr`=address[15:8]. The data phase follows on the clock after, with the data strobe active and the address strobe inactive. A new request may be accepted right after the transfer ends.
- R3: In mode 0 (`cfg_ale_mode`=0), `rw_pin` is 1 for a read and 0 for a write. It takes its value at the start of the address phase and keeps it until the next transfer's address phase.
- R4: In mode 1, `addr_strobe` is 1 only in the address phase. `data_strobe` is 0 only in the data phases of a read, and `rw_pin` is 0 only in the data phases of a write.
- R5: `mux_oe` is 1 in the address phase and in the data phases of a write, where `mux_out` equals the write data. It is 0 in idle phases and in the data phases of a read.
- R6: A read captures `mux_in` on the clock edge that ends its last data phase. On the following clock, `core_rvalid` is 1 for exactly one cycle with `core_rdata` equal to the captured byte.
- R7: When `wait_n`=0 in a data phase, that data phase is repeated. Each clock with `wait_n` low adds one data phase.
- R8: When `cfg_breq_en`=0, `bus_req_n` has no effect: `bus_ack_n` stays 1 and transfers run normally.
- R9: An enabled request (`bus_req_n`=0) is sampled only in data phases and in idle second-type phases. If it is seen in any data phase of a transfer, `bus_ack_n` goes to 0 on the clock after that transfer's last data phase. If it is seen in an idle second-type phase, `bus_ack_n` goes to 0 on the next clock.
- R10: `bus_ack_n` stays 0 while the enabled request is held. One recovery clock follows its release. During the grant and the recovery clock, `ctl_oe`, `mux_oe` and `hi_oe` are all 0.
- R11: When `cfg_float`=1, `ctl_oe`, `mux_oe` and `hi_oe` are 0 while transfers keep their normal timing.
- R12: `core_ready` is 0 during the grant and the recovery clock, and during an idle second-type phase in which an enabled request is seen. A held request is accepted only after the bus is back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one clock per bus phase |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core transfer request |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | ADDR_W | Transfer address |
| core_wdata | input | DATA_W | Write data |
| core_ready | output | 1 | Request is accepted when high |
| core_rdata | output | DATA_W | Captured read data |
| core_rvalid | output | 1 | One-cycle read-data-valid pulse |
| cfg_ale_mode | input | 1 | Strobe style: 0 = address/data strobe, 1 = latch enable with separate read and write strobes |
| cfg_float | input | 1 | Software float of all bus outputs |
| cfg_breq_en | input | 1 | Enables the external bus request |
| wait_n | input | 1 | Active-low wait, repeats the data phase |
| bus_req_n | input | 1 | Active-low external bus request |
| bus_ack_n | output | 1 | Active-low bus acknowledge |
| mux_in | input | DATA_W | Shared port, pad input |
| mux_out | output | DATA_W | Shared port, pad output (address low byte or write data) |
| mux_oe | output | 1 | Shared port output enable |
| hi_addr | output | ADDR_W-DATA_W | High address port |
| hi_oe | output | 1 | High address output enable |
| addr_strobe | output | 1 | Address strobe (active low) or latch enable (active high) |
| data_strobe | output | 1 | Data strobe or read strobe, active low |
| rw_pin | output | 1 | Read/write level or write strobe (active low) |
| ctl_oe | output | 1 | Output enable of the three strobe pins |

## Verification
A wrong phase register shows on the strobes, the port enables or `core_ready` within one clock, because all of them decode that register directly. A wrong held direction shows on `rw_pin` for as long as the bus is idle. A request flag that is lost or set in the wrong phase shows as `bus_ack_n` falling one or more clocks too early or too late. The bench keeps an independent phase-level model and compares every output on every clock. So each of these faults is caught at its first wrong cycle, under both strobe modes, with and without wait phases, and around grants taken in idle phases and in the middle of a transfer.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  // Bus phase held in the sequencer state register
  typedef enum logic [2:0] {
    ST_IDLE_A  = 3'd0,  // idle, first-type phase
    ST_IDLE_B  = 3'd1,  // idle, second-type phase (request sampled)
    ST_T1      = 3'd2,  // address phase
    ST_T2      = 3'd3,  // data phase (repeated while waiting)
    ST_GRANT   = 3'd4,  // bus handed to external master
    ST_RECOVER = 3'd5   // one idle phase before driving again
  } mbc_state_e;

endpackage

// File: rtl/mbc_arbiter.sv
module mbc_arbiter (
  input  logic clk,
  input  logic rst,
  input  logic breq_en,
  input  logic breq_n,
  input  logic in_t2,
  input  logic cyc_end,
  output logic take,
  output logic pend_q
);

  // Request is live only when enabled (R8)
  assign take = breq_en & ~breq_n;

  // Remember a request seen in any data phase until the transfer ends
  always_ff @(posedge clk) begin
    if (rst)                pend_q <= 1'b0;
    else if (cyc_end)       pend_q <= 1'b0;
    else if (in_t2 && take) pend_q <= 1'b1;
  end

  // R9: the flag rises only after a data phase with an enabled request
  p_pend_from_t2_r9: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !$past(pend_q)) |-> $past(in_t2 && breq_en && !breq_n));

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wait_n,
  input  logic              take,
  input  logic              pend,
  input  logic [DATA_W-1:0] bus_in,
  output mbc_state_e        st_q,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              ready,
  output logic              cyc_end,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  mbc_state_e st_d;
  logic       accept;

  assign ready   = (st_q == ST_IDLE_A) || ((st_q == ST_IDLE_B) && !take);
  assign cyc_end = (st_q == ST_T2) && wait_n;

  always_comb begin
    st_d   = st_q;
    accept = 1'b0;
    case (st_q)
      ST_IDLE_A: begin
        if (req) begin
          st_d   = ST_T1;
          accept = 1'b1;
        end else begin
          st_d = ST_IDLE_B;
        end
      end
      ST_IDLE_B: begin
        if (take) begin
          st_d = ST_GRANT;
        end else if (req) begin
          st_d   = ST_T1;
          accept = 1'b1;
        end else begin
          st_d = ST_IDLE_A;
        end
      end
      ST_T1:      st_d = ST_T2;
      ST_T2: begin
        if (wait_n) st_d = (pend || take) ? ST_GRANT : ST_IDLE_A;
      end
      ST_GRANT: begin
        if (!take) st_d = ST_RECOVER;
      end
      ST_RECOVER: st_d = ST_IDLE_A;
      default:    st_d = ST_IDLE_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE_A;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      rvalid  <= 1'b0;
    end else begin
      st_q   <= st_d;
      rvalid <= cyc_end && !we_q;
      if (cyc_end && !we_q) rdata <= bus_in;
      if (accept) begin
        we_q    <= we;
        addr_q  <= addr;
        wdata_q <= wdata;
      end
    end
  end

  // R3: the direction does not change inside a transfer
  p_rw_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_T2) |-> $stable(we_q));

  // R7: a low wait in a data phase repeats the data phase
  p_wait_stretch_r7: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_T2) && !wait_n) |=> (st_q == ST_T2));

  // R6: read-valid is a single-cycle pulse
  p_rvalid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rvalid |=> !rvalid);

  // R9: a grant starts only from a data phase or an idle second-type phase
  p_grant_entry_r9: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_GRANT) && ($past(st_q) != ST_GRANT))
      |-> ($past(st_q) == ST_T2 || $past(st_q) == ST_IDLE_B));

  // R10: recovery lasts one clock
  p_recover_one_r10: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RECOVER) |=> (st_q == ST_IDLE_A));

endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  mbc_state_e        st_q,
  input  logic              we_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  input  logic              ale_mode,
  input  logic              sw_float,
  output logic [DATA_W-1:0] mux_out,
  output logic              mux_oe,
  output logic [HI_W-1:0]   hi_addr,
  output logic              hi_oe,
  output logic              addr_strobe,
  output logic              data_strobe,
  output logic              rw_pin,
  output logic              ctl_oe,
  output logic              ack_n
);

  logic in_t1, in_t2, granted, drive;

  assign in_t1   = (st_q == ST_T1);
  assign in_t2   = (st_q == ST_T2);
  assign granted = (st_q == ST_GRANT) || (st_q == ST_RECOVER);
  assign drive   = !sw_float && !granted;

  assign ack_n   = (st_q != ST_GRANT);
  assign ctl_oe  = drive;
  assign hi_oe   = drive;
  assign hi_addr = addr_q[ADDR_W-1:DATA_W];
  assign mux_oe  = drive && (in_t1 || (in_t2 && we_q));
  assign mux_out = in_t1 ? addr_q[DATA_W-1:0] : wdata_q;

  always_comb begin
    if (ale_mode) begin
      addr_strobe = in_t1;
      data_strobe = !(in_t2 && !we_q);
      rw_pin      = !(in_t2 && we_q);
    end else begin
      addr_strobe = !in_t1;
      data_strobe = !in_t2;
      rw_pin      = !we_q;
    end
  end

  // R5: the shared port is released in the data phase of a read
  p_read_release_r5: assert property (@(posedge clk) disable iff (rst)
    (in_t2 && !we_q) |-> !mux_oe);

  // R10: nothing is driven while the bus is granted away
  p_float_grant_r10: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> (!ctl_oe && !mux_oe && !hi_oe));

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_ready,
  output logic [DATA_W-1:0] core_rdata,
  output logic              core_rvalid,
  input  logic              cfg_ale_mode,
  input  logic              cfg_float,
  input  logic              cfg_breq_en,
  input  logic              wait_n,
  input  logic              bus_req_n,
  output logic              bus_ack_n,
  input  logic [DATA_W-1:0] mux_in,
  output logic [DATA_W-1:0] mux_out,
  output logic              mux_oe,
  output logic [HI_W-1:0]   hi_addr,
  output logic              hi_oe,
  output logic              addr_strobe,
  output logic              data_strobe,
  output logic              rw_pin,
  output logic              ctl_oe
);

  mbc_state_e        st_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              take, pend_q, cyc_end;

  mbc_arbiter u_arb (
    .clk     (clk),
    .rst     (rst),
    .breq_en (cfg_breq_en),
    .breq_n  (bus_req_n),
    .in_t2   (st_q == ST_T2),
    .cyc_end (cyc_end),
    .take    (take),
    .pend_q  (pend_q)
  );

  mbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .req     (core_req),
    .we      (core_we),
    .addr    (core_addr),
    .wdata   (core_wdata),
    .wait_n  (wait_n),
    .take    (take),
    .pend    (pend_q),
    .bus_in  (mux_in),
    .st_q    (st_q),
    .we_q    (we_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .ready   (core_ready),
    .cyc_end (cyc_end),
    .rdata   (core_rdata),
    .rvalid  (core_rvalid)
  );

  mbc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst         (rst),
    .st_q        (st_q),
    .we_q        (we_q),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .ale_mode    (cfg_ale_mode),
    .sw_float    (cfg_float),
    .mux_out     (mux_out),
    .mux_oe      (mux_oe),
    .hi_addr     (hi_addr),
    .hi_oe       (hi_oe),
    .addr_strobe (addr_strobe),
    .data_strobe (data_strobe),
    .rw_pin      (rw_pin),
    .ctl_oe      (ctl_oe),
    .ack_n       (bus_ack_n)
  );

  // R12: no request is taken while the bus is away
  p_stall_grant_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_ack_n |-> !core_ready);

endmodule

// File: tb/mux_bus_ctrl_tb.sv
`timescale 1ns/1ps
module mux_bus_ctrl_tb;

  localparam int AW = 16;
  localparam int DW = 8;
  // model phase codes
  localparam int P_IA = 0, P_IB = 1, P_AD = 2, P_DA = 3, P_GR = 4, P_RC = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          c_req = 1'b0, c_we = 1'b0;
  logic [AW-1:0] c_addr = '0;
  logic [DW-1:0] c_wd = '0;
  logic          mode = 1'b0, flt = 1'b0, ben = 1'b0, wt_n = 1'b1, brq_n = 1'b1;
  logic [DW-1:0] pin_rd = '0;

  logic          ready, rvalid, ack_n, m_oe, h_oe, as_p, ds_p, rw_p, c_oe;
  logic [DW-1:0] rdata, m_out;
  logic [AW-DW-1:0] h_addr;

  always #2.5 clk = ~clk;

  mux_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .core_req(c_req), .core_we(c_we), .core_addr(c_addr),
    .core_wdata(c_wd), .core_ready(ready), .core_rdata(rdata), .core_rvalid(rvalid),
    .cfg_ale_mode(mode), .cfg_float(flt), .cfg_breq_en(ben), .wait_n(wt_n),
    .bus_req_n(brq_n), .bus_ack_n(ack_n), .mux_in(pin_rd), .mux_out(m_out),
    .mux_oe(m_oe), .hi_addr(h_addr), .hi_oe(h_oe), .addr_strobe(as_p),
    .data_strobe(ds_p), .rw_pin(rw_p), .ctl_oe(c_oe)
  );

  // ---------------- behavioural reference ----------------
  int            m_st = P_IA;
  logic          m_we = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rd = '0;
  logic          m_rv = 1'b0, m_seen = 1'b0;
  int            m_wleft = 0, wait_cfg = 0, acc_cnt = 0;
  int            n_chk = 0, n_bad = 0;
  bit            run = 1'b0;
  string         tag = "R1";

  function automatic bit req_live();
    return ben && !brq_n;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = P_IA; m_we = 1'b0; m_addr = '0; m_wd = '0; m_rd = '0;
      m_rv = 1'b0; m_seen = 1'b0; m_wleft = 0;
    end else begin
      m_rv = 1'b0;
      if (m_st == P_IA) begin
        if (c_req) begin
          m_we = c_we; m_addr = c_addr; m_wd = c_wd; m_wleft = wait_cfg;
          acc_cnt++; m_st = P_AD;
        end else m_st = P_IB;
      end else if (m_st == P_IB) begin
        if (req_live()) m_st = P_GR;
        else if (c_req) begin
          m_we = c_we; m_addr = c_addr; m_wd = c_wd; m_wleft = wait_cfg;
          acc_cnt++; m_st = P_AD;
        end else m_st = P_IA;
      end else if (m_st == P_AD) begin
        m_st = P_DA;
      end else if (m_st == P_DA) begin
        if (req_live()) m_seen = 1'b1;
        if (!wt_n) m_wleft--;
        else begin
          if (!m_we) begin m_rd = pin_rd; m_rv = 1'b1; end
          m_st = m_seen ? P_GR : P_IA;
          m_seen = 1'b0;
        end
      end else if (m_st == P_GR) begin
        if (!req_live()) m_st = P_RC;
      end else m_st = P_IA;
    end
  end

  task automatic chk(string sig, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, sig, act, exp);
    end
  endtask

  // compare every output each clock, then drive the wait pin
  always @(negedge clk) begin
    bit drive, ad, da, gone;
    ad    = (m_st == P_AD);
    da    = (m_st == P_DA);
    gone  = (m_st == P_GR) || (m_st == P_RC);
    drive = !flt && !gone;
    if (run) begin
      chk("ready(R12)", 16'(ready), 16'((m_st == P_IA) || (m_st == P_IB && !req_live())));
      chk("ack_n(R9)", 16'(ack_n), 16'(m_st != P_GR));
      chk("ctl_oe(R10)", 16'(c_oe), 16'(drive));
      chk("hi_oe(R11)", 16'(h_oe), 16'(drive));
      chk("mux_oe(R5)", 16'(m_oe), 16'(drive && (ad || (da && m_we))));
      if (m_oe && ad) chk("mux_addr(R2)", 16'(m_out), 16'(m_addr[DW-1:0]));
      if (m_oe && da) chk("mux_wdata(R5)", 16'(m_out), 16'(m_wd));
      chk("hi_addr(R2)", 16'(h_addr), 16'(m_addr[AW-1:DW]));
      if (mode) begin
        chk("ale(R4)", 16'(as_p), 16'(ad));
        chk("rd_strobe(R4)", 16'(ds_p), 16'(!(da && !m_we)));
        chk("wr_strobe(R4)", 16'(rw_p), 16'(!(da && m_we)));
      end else begin
        chk("as_n(R2)", 16'(as_p), 16'(!ad));
        chk("ds_n(R2)", 16'(ds_p), 16'(!da));
        chk("rw(R3)", 16'(rw_p), 16'(!m_we));
      end
      chk("rvalid(R6)", 16'(rvalid), 16'(m_rv));
      if (m_rv) chk("rdata(R6)", 16'(rdata), 16'(m_rd));
    end
    #1 wt_n = !(da && m_wleft > 0);
  end

  task automatic do_cycle(bit we, logic [AW-1:0] a, logic [DW-1:0] d, int nw, logic [DW-1:0] rb);
    int c0;
    @(negedge clk); #1;
    c0 = acc_cnt; c_we = we; c_addr = a; c_wd = d; wait_cfg = nw; pin_rd = rb; c_req = 1'b1;
    while (acc_cnt == c0) @(negedge clk);
    #1 c_req = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(m_st == P_IA || m_st == P_IB));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (2) @(negedge clk);
    run = 1'b1;
    @(negedge clk); #1 rst = 1'b0;
    repeat (4) @(negedge clk);

    // R2: basic write then read, and back-to-back transfers
    tag = "R2";
    do_cycle(1'b1, 16'hA55A, 8'h3C, 0, 8'h00); wait_idle();
    do_cycle(1'b0, 16'h1234, 8'h00, 0, 8'hC3);
    do_cycle(1'b1, 16'h4321, 8'h81, 0, 8'h00); wait_idle();

    // R3: direction level held through idle phases
    tag = "R3";
    do_cycle(1'b1, 16'h0F0F, 8'h11, 0, 8'h00); wait_idle(); repeat (4) @(negedge clk);
    do_cycle(1'b0, 16'hF0F0, 8'h00, 0, 8'h22); wait_idle(); repeat (4) @(negedge clk);

    // R5: write data on the shared port
    tag = "R5";
    do_cycle(1'b1, 16'hBEEF, 8'h77, 1, 8'h00); wait_idle();

    // R6: read capture and valid pulse
    tag = "R6";
    do_cycle(1'b0, 16'h00FF, 8'h00, 0, 8'h5A); wait_idle(); repeat (2) @(negedge clk);

    // R7: wait stretching on read and write
    tag = "R7";
    do_cycle(1'b0, 16'h2468, 8'h00, 2, 8'h96); wait_idle();
    do_cycle(1'b1, 16'h1357, 8'hE4, 3, 8'h00); wait_idle();

    // R4: latch-enable mode with split strobes
    tag = "R4";
    @(negedge clk); #1 mode = 1'b1;
    do_cycle(1'b0, 16'hCAFE, 8'h00, 1, 8'h69); wait_idle();
    do_cycle(1'b1, 16'hFACE, 8'hB2, 2, 8'h00); wait_idle();
    @(negedge clk); #1 mode = 1'b0;

    // R8: request ignored while disabled
    tag = "R8";
    @(negedge clk); #1 ben = 1'b0; brq_n = 1'b0;
    repeat (6) @(negedge clk);
    do_cycle(1'b1, 16'h5151, 8'h44, 1, 8'h00); wait_idle();
    @(negedge clk); #1 brq_n = 1'b1;

    // R9: request during a transfer takes effect after it ends
    tag = "R9";
    @(negedge clk); #1 ben = 1'b1;
    do_cycle(1'b1, 16'h7777, 8'h55, 3, 8'h00);
    brq_n = 1'b0;
    // R12: a core request waits until the bus is back (R10 recovery)
    tag = "R12";
    fork
      begin repeat (10) @(negedge clk); #1 brq_n = 1'b1; end
      do_cycle(1'b0, 16'h8888, 8'h00, 0, 8'hA7);
    join
    wait_idle();

    // R10: grant taken from an idle bus and released
    tag = "R10";
    repeat (3) @(negedge clk); #1 brq_n = 1'b0;
    repeat (6) @(negedge clk); #1 brq_n = 1'b1;
    repeat (4) @(negedge clk);
    @(negedge clk); #1 ben = 1'b0;

    // R11: software float keeps timing but releases the pins
    tag = "R11";
    @(negedge clk); #1 flt = 1'b1;
    do_cycle(1'b1, 16'h3C3C, 8'h99, 1, 8'h00); wait_idle();
    do_cycle(1'b0, 16'hC3C3, 8'h00, 0, 8'h1E); wait_idle();
    @(negedge clk); #1 flt = 1'b0;
    repeat (4) @(negedge clk);

    finish_run();
  end

endmodule